// File: doc/BRIEF.md
# Instruction-Count Timer Interrupt Unit

This unit sits beside a one-instruction subtract-and-branch core and produces a periodic interrupt. It counts instructions, not clock cycles. Only a standard subtract that completes without taking its branch moves the count. The core reports each completed instruction with a one-cycle pulse and says whether the branch was taken and whether the instruction was an I/O operation.

The contents of memory word 0 hold the handler address, and they are also the enable: a zero value disables the unit. Suppose a qualifying instruction completes while word 0 is nonzero, and the count as it stood before that instruction is above the threshold. The unit then performs an interrupt entry and clears the count. On entry it issues a write of the return PC, as a byte address, to memory word 1. In the same cycle it forces the PC to the handler's word index, so both take effect before the core's next fetch.

The core must hold off its next fetch for the one cycle after its completion pulse. That gives the entry outputs time to land. The threshold is a parameter.

Top module: `irq_step_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_wr_o` and `pc_ovr_o` are low. The instruction count starts at zero.
- R2: An instruction qualifies only when `retire_i` is high with both `taken_i` and `io_i` low. A retire with `taken_i` or `io_i` high neither advances the count nor causes an entry.
- R3: While `vec_word_i` is zero, no entry is taken and the count holds its value. Counting resumes from that value once the word becomes nonzero again.
- R4: An entry is taken on a qualifying instruction when `vec_word_i` is nonzero and the count before the increment exceeds `THRESH`. Starting from zero, that is the (`THRESH`+2)-th qualifying instruction. After an entry the count is zero, so the next entry comes a further `THRESH`+2 qualifying instructions later.
- R5: The entry write appears in the cycle after the triggering `retire_i` pulse: `mem_wr_o` is high, `mem_waddr_o` equals 1, and `mem_wdata_o` equals `pc_i` shifted left by two, truncated to `DW` bits, with `pc_i` sampled at the pulse.
- R6: In the same cycle as the entry write, `pc_ovr_o` is high and `pc_new_o` equals `vec_word_i` shifted right by two, sampled at the pulse.
- R7: `mem_wr_o` and `pc_ovr_o` are always equal, and each entry is a single-cycle pulse.
- R8: Taken branches and I/O instructions interleaved among qualifying ones do not change which qualifying instruction triggers the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retire_i | input | 1 | One-cycle pulse when the core completes an instruction |
| taken_i | input | 1 | The completing instruction took its branch |
| io_i | input | 1 | The completing instruction was an I/O operation |
| pc_i | input | AW | Word index of the next instruction |
| vec_word_i | input | DW | Current contents of memory word 0 (handler byte address) |
| mem_wr_o | output | 1 | Write request for the return-PC save |
| mem_waddr_o | output | AW | Word index of the save (always 1) |
| mem_wdata_o | output | DW | Return PC as a byte address |
| pc_ovr_o | output | 1 | Forces the core's PC |
| pc_new_o | output | AW | Handler word index loaded into the PC |

## Verification
Every cycle, the assertions check that the write and the PC override pulse together for one cycle only. They also check that each entry follows a qualifying completion with word 0 nonzero, that the saved data and target match the inputs of that cycle, and that the count never exceeds `THRESH`+1. Only the bench scenarios can show the exact spacing of entries: the (`THRESH`+2)-th qualifying instruction, the count held across a disabled interval, and the gaps that taken branches and I/O leave uncounted.

// File: rtl/irqt_pkg.sv
// Shared constants and helpers for the instruction-count timer interrupt unit.
// Assumes word-indexed PCs and byte-addressed handler vectors (4 bytes/word).
package irqt_pkg;
    // Word index receiving the saved return PC
    localparam int unsigned SAVE_WORD = 1;
    // Byte offset bits inside one word
    localparam int unsigned BYTE_SHIFT = 2;

    // Event kind seen at instruction completion
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_COUNT = 2'd1,
        EV_SKIP  = 2'd2
    } ev_kind_t;
endpackage

// File: rtl/irqt_qualify.sv
// Classifies each completion pulse: only a non-branching, non-I/O subtract
// counts. Assumes retire_i is a single-cycle pulse per instruction.
module irqt_qualify
    import irqt_pkg::*;
(
    input  logic     retire_i,
    input  logic     taken_i,
    input  logic     io_i,
    output ev_kind_t kind_o
);
    // Map the completion flags to an event kind
    always_comb begin
        if (!retire_i)            kind_o = EV_NONE;
        else if (taken_i || io_i) kind_o = EV_SKIP;
        else                      kind_o = EV_COUNT;
    end
endmodule

// File: rtl/irqt_counter.sv
// Instruction counter and trigger decision. The enable test comes first:
// while the vector word is zero the count holds. Comparison uses the value
// before the increment; a trigger clears the count.
module irqt_counter
    import irqt_pkg::*;
#(
    parameter int unsigned THRESH = 300000,
    parameter int unsigned CW     = $clog2(THRESH + 2) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ev_kind_t      kind_i,
    input  logic          enabled_i,
    output logic          fire_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    logic [CW-1:0] cnt_q;

    // Trigger when enabled, qualifying and past the limit
    always_comb fire_o = (kind_i == EV_COUNT) && enabled_i && (cnt_q > LIMIT);

    // Advance, clear on trigger, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)                                    cnt_q <= '0;
        else if (fire_o)                               cnt_q <= '0;
        else if ((kind_i == EV_COUNT) && enabled_i)    cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/irqt_entry.sv
// Registers the interrupt entry: one-cycle save write of the return byte
// address and one-cycle PC override to the handler word index.
// Assumes the core waits one cycle after its completion pulse before fetching.
module irqt_entry
    import irqt_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] vec_i,
    output logic          go_o,
    output logic [DW-1:0] save_o,
    output logic [AW-1:0] target_o
);
    localparam int unsigned PW = AW + BYTE_SHIFT;

    logic [PW-1:0] pc_bytes;
    logic [DW-1:0] vec_words;

    // Byte address of the return point and word index of the handler
    always_comb begin
        pc_bytes  = {pc_i, {BYTE_SHIFT{1'b0}}};
        vec_words = vec_i >> BYTE_SHIFT;
    end

    // Pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) go_o <= 1'b0;
        else        go_o <= fire_i;
    end

    // Payload captured at the triggering completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_o   <= '0;
            target_o <= '0;
        end else if (fire_i) begin
            save_o   <= DW'(pc_bytes);
            target_o <= AW'(vec_words);
        end
    end
endmodule

// File: rtl/irq_step_timer.sv
// Top of the instruction-count timer interrupt unit. Counts completed
// non-branching subtracts while memory word 0 is nonzero and, past the
// threshold, saves the return byte address to word 1 and redirects the PC.
module irq_step_timer
    import irqt_pkg::*;
#(
    parameter int unsigned DW     = 32,
    parameter int unsigned AW     = 30,
    parameter int unsigned THRESH = 300000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retire_i,
    input  logic          taken_i,
    input  logic          io_i,
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] vec_word_i,
    output logic          mem_wr_o,
    output logic [AW-1:0] mem_waddr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          pc_ovr_o,
    output logic [AW-1:0] pc_new_o
);
    localparam int unsigned CW = $clog2(THRESH + 2) + 1;

    ev_kind_t      kind;
    logic          enabled;
    logic          fire;
    logic          go;
    logic [CW-1:0] cnt;

    // Word 0 nonzero is the enable
    always_comb enabled = (vec_word_i != '0);

    irqt_qualify u_qualify (
        .retire_i (retire_i),
        .taken_i  (taken_i),
        .io_i     (io_i),
        .kind_o   (kind)
    );

    irqt_counter #(.THRESH(THRESH), .CW(CW)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind_i    (kind),
        .enabled_i (enabled),
        .fire_o    (fire),
        .cnt_o     (cnt)
    );

    irqt_entry #(.DW(DW), .AW(AW)) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .pc_i     (pc_i),
        .vec_i    (vec_word_i),
        .go_o     (go),
        .save_o   (mem_wdata_o),
        .target_o (pc_new_o)
    );

    assign mem_wr_o    = go;
    assign pc_ovr_o    = go;
    assign mem_waddr_o = AW'(SAVE_WORD);
endmodule

// File: rtl/irqt_checker.sv
// Property checker for irq_step_timer, attached by bind. Observes ports and
// the internal instruction count.
module irqt_checker #(
    parameter int unsigned DW     = 32,
    parameter int unsigned AW     = 30,
    parameter int unsigned THRESH = 300000,
    parameter int unsigned CW     = $clog2(THRESH + 2) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          retire_i,
    input logic          taken_i,
    input logic          io_i,
    input logic [AW-1:0] pc_i,
    input logic [DW-1:0] vec_word_i,
    input logic          mem_wr_o,
    input logic [AW-1:0] mem_waddr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          pc_ovr_o,
    input logic [AW-1:0] pc_new_o,
    input logic [CW-1:0] cnt
);
    logic rst_seen_q;

    // Remembers that reset was asserted at the previous edge
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Outputs are quiet right after a reset edge
    always_ff @(posedge clk) begin
        if (rst_seen_q == 1'b1)
            AST_RESET_QUIET: assert (!mem_wr_o && !pc_ovr_o); // R1
    end

    AST_QUALIFIED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ovr_o |-> $past(retire_i && !taken_i && !io_i)); // R2

    AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ovr_o |-> ($past(vec_word_i) != '0)); // R3

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(THRESH + 1)); // R4

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ovr_o |-> (cnt == '0)); // R4

    AST_SAVE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (mem_waddr_o == AW'(1))); // R5

    AST_SAVE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (mem_wdata_o == DW'({$past(pc_i), 2'b00}))); // R5

    AST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ovr_o |-> (pc_new_o == AW'($past(vec_word_i) >> 2))); // R6

    AST_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o == pc_ovr_o); // R7

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ovr_o |=> !pc_ovr_o); // R7
endmodule

bind irq_step_timer irqt_checker #(.DW(DW), .AW(AW), .THRESH(THRESH)) u_irqt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire_i    (retire_i),
    .taken_i     (taken_i),
    .io_i        (io_i),
    .pc_i        (pc_i),
    .vec_word_i  (vec_word_i),
    .mem_wr_o    (mem_wr_o),
    .mem_waddr_o (mem_waddr_o),
    .mem_wdata_o (mem_wdata_o),
    .pc_ovr_o    (pc_ovr_o),
    .pc_new_o    (pc_new_o),
    .cnt         (cnt)
);

// File: tb/test_irq_step_timer.sv
// Directed bench for irq_step_timer with a small threshold.
module test_irq_step_timer;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 30;
    localparam int unsigned TH = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          retire_i = 1'b0;
    logic          taken_i = 1'b0;
    logic          io_i = 1'b0;
    logic [AW-1:0] pc_i = '0;
    logic [DW-1:0] vec_word_i = '0;
    logic          mem_wr_o;
    logic [AW-1:0] mem_waddr_o;
    logic [DW-1:0] mem_wdata_o;
    logic          pc_ovr_o;
    logic [AW-1:0] pc_new_o;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_step_timer #(.DW(DW), .AW(AW), .THRESH(TH)) i_irq_step_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .retire_i    (retire_i),
        .taken_i     (taken_i),
        .io_i        (io_i),
        .pc_i        (pc_i),
        .vec_word_i  (vec_word_i),
        .mem_wr_o    (mem_wr_o),
        .mem_waddr_o (mem_waddr_o),
        .mem_wdata_o (mem_wdata_o),
        .pc_ovr_o    (pc_ovr_o),
        .pc_new_o    (pc_new_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One completion pulse; checks the entry outputs in the following cycle
    task automatic issue(input bit tk, input bit io, input logic [AW-1:0] pc, input string req);
        bit qual;
        bit exp_fire;
        logic [DW-1:0] vec_s;
        qual     = !tk && !io;
        exp_fire = qual && (vec_word_i != 0) && (ref_cnt > TH);
        vec_s    = vec_word_i;
        if (exp_fire) ref_cnt = 0;
        else if (qual && vec_word_i != 0) ref_cnt++;
        retire_i = 1'b1; taken_i = tk; io_i = io; pc_i = pc;
        @(negedge clk);
        retire_i = 1'b0; taken_i = 1'b0; io_i = 1'b0;
        check({req, " override"}, 64'(pc_ovr_o), 64'(exp_fire));
        check("R7 paired", 64'(mem_wr_o), 64'(pc_ovr_o));
        if (exp_fire) begin
            check("R5 addr", 64'(mem_waddr_o), 64'd1);
            check("R5 data", 64'(mem_wdata_o), 64'(DW'({pc, 2'b00})));
            check("R6 target", 64'(pc_new_o), 64'(AW'(vec_s >> 2)));
            @(negedge clk);
            check("R7 single pulse", 64'(pc_ovr_o | mem_wr_o), 64'd0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 wr in reset", 64'(mem_wr_o), 64'd0);
        check("R1 ovr in reset", 64'(pc_ovr_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 64'(pc_ovr_o), 64'd0);
        ref_cnt = 0;
    endtask

    task automatic t_disabled();
        vec_word_i = '0;
        for (int i = 0; i < 20; i++) issue(1'b0, 1'b0, AW'(100 + i), "R3 disabled");
    endtask

    task automatic t_first_entry();
        vec_word_i = 32'h0000_0400;
        // count held at zero: seventh qualifying instruction enters
        for (int i = 0; i < TH + 2; i++) issue(1'b0, 1'b0, AW'(200 + i), "R4 first entry");
    endtask

    task automatic t_mixed();
        // fire still on the seventh qualifying instruction
        for (int i = 0; i < TH + 2; i++) begin
            issue(1'b1, 1'b0, AW'(300 + i), "R2 taken skip");
            issue(1'b0, 1'b1, AW'(400 + i), "R2 io skip");
            issue(1'b0, 1'b0, AW'(500 + i), "R8 interleaved");
        end
    endtask

    task automatic t_second();
        vec_word_i = 32'h0000_1234;
        for (int i = 0; i < TH + 2; i++) issue(1'b0, 1'b0, AW'(600 + i), "R4 second entry");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 3; i++) issue(1'b0, 1'b0, AW'(700 + i), "R3 pre-hold");
        vec_word_i = '0;
        for (int i = 0; i < 10; i++) issue(1'b0, 1'b0, AW'(710 + i), "R3 held");
        vec_word_i = 32'h0000_0800;
        for (int i = 0; i < 4; i++) issue(1'b0, 1'b0, AW'(720 + i), "R3 resume");
    endtask

    task automatic t_wrap();
        vec_word_i = 32'hFFFF_FFFD;
        for (int i = 0; i < TH + 1; i++) issue(1'b0, 1'b0, AW'(800 + i), "R4 wrap lead");
        issue(1'b0, 1'b0, {AW{1'b1}}, "R5 wrap entry");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_disabled();
        t_first_entry();
        t_mixed();
        t_second();
        t_hold();
        t_wrap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule